// File: doc/BRIEF.md
# Paged Array Read Address Sequencer

This block produces the running byte address for a sequential read that streams through a flash array of 8192 pages. A host-side command decoder hands it the 24-bit address field of a read command together with a load strobe. The sequencer splits that field into a page index and a byte-in-page index and registers them. Every later advance strobe then steps the address by one byte, so the storage read path always sees the address of the next byte to fetch.

Two page geometries are supported, chosen by a mode input. With 528-byte pages the field holds a 13-bit page number above a 10-bit byte offset, and the offset counts 0 to 527. With 512-byte pages the field is a 22-bit linear address whose upper 13 bits name the page, and the offset counts 0 to 511. At the end of a page the sequencer moves to byte 0 of the next page in the same cycle. After the last page it returns to page 0. No idle cycle is inserted in either case.

The mode is expected to stay constant between one load and the next.

Top module: `page_addr_seq`

## Requirements
- R1: While rst_n is low, and after it is released, page_idx and byte_idx are both 0 until the first load or advance.
- R2: With long_mode=1, a load sets page_idx to start_field[22:10] and byte_idx to start_field[9:0] on the next cycle. Bit 23 is ignored.
- R3: With long_mode=0, a load sets page_idx to start_field[21:9] and byte_idx to start_field[8:0] on the next cycle. Bits 23:22 are ignored.
- R4: With long_mode=1, a loaded byte value of 528 or more is clamped, so byte_idx becomes 527.
- R5: An advance without a load, when not at the last byte of a page, raises byte_idx by one on the next cycle and leaves page_idx unchanged.
- R6: With long_mode=1, an advance at byte 527 gives byte 0 of the next page on the next cycle.
- R7: With long_mode=0, an advance at byte 511 gives byte 0 of the next page on the next cycle.
- R8: An advance at the last byte of page 8191 gives page 0, byte 0 on the next cycle, in either mode.
- R9: When load and advance are high in the same cycle, the loaded address is taken and the advance is dropped.
- R10: With both load and advance low, page_idx and byte_idx hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_mode | input | 1 | 1 selects 528-byte pages, 0 selects 512-byte pages |
| load | input | 1 | Capture a start address from start_field |
| start_field | input | 24 | Command address field |
| advance | input | 1 | Step the address by one byte |
| page_idx | output | 13 | Current page index |
| byte_idx | output | 10 | Current byte index within the page |

## Verification
The bound checker watches every cycle. It confirms that idle cycles hold the address, that an advance inside a page adds exactly one, that each mode's last byte rolls into the next page with no stall, that the last page wraps to page 0, and that a load (including one that coincides with an advance) yields the split and clamped start address. Some behaviour can only be shown by the bench's scenarios. These are the exact values after reset, runs of several advances that start from chosen offsets and cross a page boundary, and proof that the ignored upper field bits really make no difference when they are set to one.

// File: rtl/pas_pkg.sv
package pas_pkg;
   typedef enum logic {
      GEOM_BIN = 1'b0,
      GEOM_EXT = 1'b1
   } geom_e;
endpackage

// File: rtl/pas_field_split.sv
module pas_field_split
   import pas_pkg::*;
#(
   parameter int PAGE_W    = 13,
   parameter int BYTE_W    = 10,
   parameter int SHORT_BW  = 9,
   parameter int FIELD_W   = 24,
   parameter int LONG_PAGE = 528
) (
   input  logic [FIELD_W-1:0] field,
   input  geom_e              geom,
   output logic [PAGE_W-1:0]  page_o,
   output logic [BYTE_W-1:0]  byte_o
);
   localparam int LONG_USED  = PAGE_W + BYTE_W;
   localparam int SHORT_USED = PAGE_W + SHORT_BW;
   localparam logic [BYTE_W-1:0] LAST_L = BYTE_W'(LONG_PAGE - 1);

   logic [BYTE_W-1:0] long_byte;
   assign long_byte = field[BYTE_W-1:0];

   always_comb begin
      if (geom == GEOM_EXT) begin
         page_o = field[LONG_USED-1:BYTE_W];
         byte_o = (long_byte > LAST_L) ? LAST_L : long_byte;
      end else begin
         page_o = field[SHORT_USED-1:SHORT_BW];
         byte_o = BYTE_W'(field[SHORT_BW-1:0]);
      end
   end

   generate
      if (FIELD_W > LONG_USED) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^field[FIELD_W-1:LONG_USED];
      end
   endgenerate
endmodule

// File: rtl/pas_byte_ctr.sv
module pas_byte_ctr
   import pas_pkg::*;
#(
   parameter int BYTE_W     = 10,
   parameter int LONG_PAGE  = 528,
   parameter int SHORT_PAGE = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  geom_e             geom,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              advance,
   output logic [BYTE_W-1:0] byte_q,
   output logic              carry
);
   localparam logic [BYTE_W-1:0] LAST_L = BYTE_W'(LONG_PAGE - 1);
   localparam logic [BYTE_W-1:0] LAST_S = BYTE_W'(SHORT_PAGE - 1);

   logic [BYTE_W-1:0] last_b;
   logic              at_last;

   assign last_b  = (geom == GEOM_EXT) ? LAST_L : LAST_S;
   assign at_last = (byte_q >= last_b);
   assign carry   = advance && !load && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_q <= '0;
      end else if (load) begin
         byte_q <= load_val;
      end else if (advance) begin
         byte_q <= at_last ? '0 : byte_q + 1'b1;
      end
   end
endmodule

// File: rtl/pas_page_ctr.sv
module pas_page_ctr #(
   parameter int PAGE_W    = 13,
   parameter int NUM_PAGES = 8192
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PAGE_W-1:0] load_val,
   input  logic              step,
   output logic [PAGE_W-1:0] page_q
);
   localparam logic [PAGE_W-1:0] LAST_P = PAGE_W'(NUM_PAGES - 1);

   logic [PAGE_W-1:0] page_nxt;

   generate
      if (NUM_PAGES == (1 << PAGE_W)) begin : g_pow2
         assign page_nxt = page_q + 1'b1;
      end else begin : g_cmp
         assign page_nxt = (page_q >= LAST_P) ? '0 : page_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (load) begin
         page_q <= load_val;
      end else if (step) begin
         page_q <= page_nxt;
      end
   end
endmodule

// File: rtl/page_addr_seq.sv
module page_addr_seq
   import pas_pkg::*;
#(
   parameter int PAGE_W     = 13,
   parameter int NUM_PAGES  = 8192,
   parameter int LONG_PAGE  = 528,
   parameter int SHORT_PAGE = 512,
   parameter int FIELD_W    = 24,
   parameter int BYTE_W     = $clog2(LONG_PAGE),
   parameter int SHORT_BW   = $clog2(SHORT_PAGE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              long_mode,
   input  logic              load,
   input  logic [FIELD_W-1:0] start_field,
   input  logic              advance,
   output logic [PAGE_W-1:0] page_idx,
   output logic [BYTE_W-1:0] byte_idx
);
   generate
      if (NUM_PAGES > (1 << PAGE_W) || NUM_PAGES < 2) begin : g_bad_pages
         $error("page_addr_seq: NUM_PAGES does not fit PAGE_W");
      end
      if (SHORT_PAGE != (1 << SHORT_BW) || LONG_PAGE <= SHORT_PAGE) begin : g_bad_geom
         $error("page_addr_seq: page sizes inconsistent");
      end
      if (FIELD_W < PAGE_W + BYTE_W || SHORT_BW >= BYTE_W) begin : g_bad_field
         $error("page_addr_seq: address field too narrow");
      end
   endgenerate

   geom_e             geom;
   logic [PAGE_W-1:0] ld_page;
   logic [BYTE_W-1:0] ld_byte;
   logic              byte_carry;

   assign geom = long_mode ? GEOM_EXT : GEOM_BIN;

   pas_field_split #(
      .PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .SHORT_BW(SHORT_BW),
      .FIELD_W(FIELD_W), .LONG_PAGE(LONG_PAGE)
   ) u_split (
      .field (start_field),
      .geom  (geom),
      .page_o(ld_page),
      .byte_o(ld_byte)
   );

   pas_byte_ctr #(
      .BYTE_W(BYTE_W), .LONG_PAGE(LONG_PAGE), .SHORT_PAGE(SHORT_PAGE)
   ) u_byte (
      .clk     (clk),
      .rst_n   (rst_n),
      .geom    (geom),
      .load    (load),
      .load_val(ld_byte),
      .advance (advance),
      .byte_q  (byte_idx),
      .carry   (byte_carry)
   );

   pas_page_ctr #(
      .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES)
   ) u_page (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .load_val(ld_page),
      .step    (byte_carry),
      .page_q  (page_idx)
   );
endmodule

// File: rtl/pas_checker.sv
module pas_checker #(
   parameter int PAGE_W     = 13,
   parameter int NUM_PAGES  = 8192,
   parameter int LONG_PAGE  = 528,
   parameter int SHORT_PAGE = 512,
   parameter int FIELD_W    = 24,
   parameter int BYTE_W     = 10,
   parameter int SHORT_BW   = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              long_mode,
   input logic              load,
   input logic [FIELD_W-1:0] start_field,
   input logic              advance,
   input logic [PAGE_W-1:0] page_idx,
   input logic [BYTE_W-1:0] byte_idx
);
   localparam logic [BYTE_W-1:0] LAST_L = BYTE_W'(LONG_PAGE - 1);
   localparam logic [BYTE_W-1:0] LAST_S = BYTE_W'(SHORT_PAGE - 1);
   localparam logic [PAGE_W-1:0] LAST_P = PAGE_W'(NUM_PAGES - 1);
   localparam int LONG_USED  = PAGE_W + BYTE_W;
   localparam int SHORT_USED = PAGE_W + SHORT_BW;

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> ($stable(page_idx) && $stable(byte_idx)));

   assert_step_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && long_mode && byte_idx < LAST_L) |=>
      (byte_idx == BYTE_W'($past(byte_idx) + 1'b1) && $stable(page_idx)));

   assert_step_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && !long_mode && byte_idx < LAST_S) |=>
      (byte_idx == BYTE_W'($past(byte_idx) + 1'b1) && $stable(page_idx)));

   assert_roll_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && long_mode && byte_idx == LAST_L && page_idx != LAST_P) |=>
      (byte_idx == '0 && page_idx == PAGE_W'($past(page_idx) + 1'b1)));

   assert_roll_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && !long_mode && byte_idx == LAST_S && page_idx != LAST_P) |=>
      (byte_idx == '0 && page_idx == PAGE_W'($past(page_idx) + 1'b1)));

   assert_array_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && page_idx == LAST_P &&
       byte_idx == (long_mode ? LAST_L : LAST_S)) |=>
      (byte_idx == '0 && page_idx == '0));

   assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && long_mode && start_field[BYTE_W-1:0] > LAST_L) |=>
      (byte_idx == LAST_L && page_idx == $past(start_field[LONG_USED-1:BYTE_W])));

   assert_load_long_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && long_mode && start_field[BYTE_W-1:0] <= LAST_L) |=>
      (byte_idx == $past(start_field[BYTE_W-1:0]) &&
       page_idx == $past(start_field[LONG_USED-1:BYTE_W])));

   assert_load_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !long_mode) |=>
      (byte_idx == BYTE_W'($past(start_field[SHORT_BW-1:0])) &&
       page_idx == $past(start_field[SHORT_USED-1:SHORT_BW])));

   assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && advance && !long_mode) |=>
      (page_idx == $past(start_field[SHORT_USED-1:SHORT_BW])));
endmodule

bind page_addr_seq pas_checker #(
   .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES), .LONG_PAGE(LONG_PAGE),
   .SHORT_PAGE(SHORT_PAGE), .FIELD_W(FIELD_W), .BYTE_W(BYTE_W), .SHORT_BW(SHORT_BW)
) u_pas_checker (
   .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .load(load),
   .start_field(start_field), .advance(advance),
   .page_idx(page_idx), .byte_idx(byte_idx)
);

// File: tb/tb_page_addr_seq.sv
module tb_page_addr_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        long_mode = 1'b1;
   logic        load = 1'b0;
   logic [23:0] start_field = '0;
   logic        advance = 1'b0;
   logic [12:0] page_idx;
   logic [9:0]  byte_idx;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   page_addr_seq dut (
      .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .load(load),
      .start_field(start_field), .advance(advance),
      .page_idx(page_idx), .byte_idx(byte_idx)
   );

   task automatic check(input string tag, input int exp_p, input int exp_b);
      n_checks++;
      if (page_idx !== 13'(exp_p) || byte_idx !== 10'(exp_b)) begin
         n_fails++;
         $display("FAIL %s: actual page=%0d byte=%0d expected page=%0d byte=%0d",
                  tag, page_idx, byte_idx, exp_p, exp_b);
      end
   endtask

   // inputs change at negedge; outputs sampled at negedge after one posedge
   task automatic do_load(input logic lm, input logic [23:0] f);
      long_mode   = lm;
      start_field = f;
      load        = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic do_adv(input int n);
      advance = 1'b1;
      for (int i = 0; i < n; i++) @(negedge clk);
      advance = 1'b0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 in reset", 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 0, 0);
   endtask

   task automatic t_long_load_step;
      do_load(1'b1, {1'b1, 13'd100, 10'd300});
      check("R2 long split, bit23 ignored", 100, 300);
      do_adv(5);
      check("R5 five advances", 100, 305);
      repeat (3) @(negedge clk);
      check("R10 idle hold", 100, 305);
   endtask

   task automatic t_clamp;
      do_load(1'b1, {1'b0, 13'd7, 10'd1000});
      check("R4 clamp to 527", 7, 527);
      do_adv(1);
      check("R6 clamped byte rolls", 8, 0);
      do_load(1'b1, {1'b0, 13'd9, 10'd528});
      check("R4 clamp at 528", 9, 527);
   endtask

   task automatic t_long_cross;
      do_load(1'b1, {1'b0, 13'd50, 10'd525});
      do_adv(2);
      check("R5 reach 527", 50, 527);
      do_adv(2);
      check("R6 cross into next page", 51, 1);
   endtask

   task automatic t_short;
      do_load(1'b0, {2'b11, 13'd200, 9'd510});
      check("R3 short split, bits 23:22 ignored", 200, 510);
      do_adv(2);
      check("R7 511 rolls to next page", 201, 0);
      do_load(1'b0, {2'b00, 13'd3, 9'd0});
      do_adv(512);
      check("R7 full page traversal", 4, 0);
   endtask

   task automatic t_wrap;
      do_load(1'b0, {2'b00, 13'd8191, 9'd509});
      do_adv(3);
      check("R8 short array wrap", 0, 0);
      do_load(1'b1, {1'b0, 13'd8191, 10'd526});
      do_adv(2);
      check("R8 long array wrap", 0, 0);
      do_adv(1);
      check("R8 continue after wrap", 0, 1);
   endtask

   task automatic t_priority;
      do_load(1'b1, {1'b0, 13'd40, 10'd10});
      advance = 1'b1;
      do_load(1'b1, {1'b0, 13'd77, 10'd527});
      advance = 1'b0;
      check("R9 load beats advance (long)", 77, 527);
      advance = 1'b1;
      do_load(1'b0, {2'b00, 13'd12, 9'd511});
      advance = 1'b0;
      check("R9 load beats advance (short)", 12, 511);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_long_load_step();
      t_clamp();
      t_long_cross();
      t_short();
      t_wrap();
      t_priority();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule